// File: doc/BRIEF.md
# Phase-Shifted PWM Channel with Deferred Register Loading

This block is one pulse-width output channel. A free-running period counter steps from zero up to the programmed period minus one and then wraps. The output is active while the count is at or above a programmable start phase and below a programmable end point. The active time per period is therefore the end point minus the start phase. A polarity setting selects whether active means high or low. The block also emits a one-clock strobe at each period wrap, so that a group controller can line up several channels.

Software writes the period, end point, start phase and polarity through one write port. Each write goes into a staging copy first. The running waveform never picks up a staged value in the middle of a period. A write with its sync flag clear is taken at the next wrap. A write with its sync flag set waits for a group-wide commit pulse and is then taken at the wrap that follows. Several channels can therefore change together, and two channels with the same period can run a half period apart: set the start phase to half the period and raise the end point by the same amount.

Top module: `pwm_phase_channel`

## Requirements
- R1: The count runs 0 to P-1 and then wraps, where P is the active period. `period_end` is high for exactly one clock per wrap, in the same output cycle as the count P-1. Consecutive strobes are therefore P clocks apart.
- R2: `pwm_out` shows the active level in the output cycle for count c exactly when shift <= c < duty. The active time per period is therefore duty - shift clocks. The output is registered: it lags the count by one clock.
- R3: If shift >= duty, the output stays at its inactive level for the whole period.
- R4: Polarity value 0 (data bit 0) makes the active level 1 and the inactive level 0. Polarity value 1 inverts both levels.
- R5: A write with `cfg_sync`=0 is staged and applied at the next wrap. The period in which the write occurs keeps its old waveform.
- R6: A write with `cfg_sync`=1 is not applied at any wrap until a `grp_commit` pulse arrives. It is applied at the first wrap after that pulse.
- R7: While `enable` is 0, the output holds the inactive level, `period_end` stays 0 and the count stays 0. Writes take effect at once. After `enable` rises, the first strobe comes after P clocks, using the values written.
- R8: A programmed period of 0 or 1 behaves as a period of 2.
- R9: After reset the output and strobe are 0, and the active and staged values are period 2, duty 0, shift 0, polarity 0.
- R10: With period P, shift P/2 and duty P/2+D, the active window begins P/2 clocks after the wrap and lasts D clocks.
- R11: `cfg_sel` encodes the field: 0 period, 1 duty, 2 shift, 3 polarity. A write to one field leaves the other fields unchanged. If a field is written twice before it is applied, the later write decides both the value and how it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the channel; 0 holds it idle |
| cfg_we | input | 1 | Write strobe for one field |
| cfg_sel | input | 2 | Field select: 0 period, 1 duty, 2 shift, 3 polarity |
| cfg_sync | input | 1 | 1 = wait for group commit before applying |
| cfg_data | input | CNT_W | Value written (polarity uses bit 0) |
| grp_commit | input | 1 | Group-wide release of writes made with sync set |
| pwm_out | output | 1 | Waveform output |
| period_end | output | 1 | One-clock strobe at each period wrap |

## Verification
The hardest case to reach is a write that lands on the exact clock of a wrap. This is where an apply and a new stage of the same field collide. A second hard case is a commit pulse that coincides with a wrap, which must push the apply to the following boundary. Directed phases cannot aim at these cycles reliably. The bench therefore runs a long stretch of short random periods, with writes, sync flags, commit pulses and enable drops at random cycles. This makes both collisions happen many times. Every output cycle is compared against a behavioural model, and any mid-period change or early apply shows up as a mismatch.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  typedef enum logic [1:0] {
    FLD_PERIOD = 2'd0,
    FLD_DUTY   = 2'd1,
    FLD_SHIFT  = 2'd2,
    FLD_POL    = 2'd3
  } pwm_field_e;

  localparam int unsigned NUM_CNT_FIELDS = 3;
  localparam int unsigned MIN_PERIOD     = 2;
endpackage

// File: rtl/pwm_stage_field.sv
module pwm_stage_field #(
  parameter int unsigned W       = 34,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         boundary,
  input  logic         grp_commit,
  input  logic         we,
  input  logic         sync,
  input  logic [W-1:0] din,
  output logic [W-1:0] act
);
  logic [W-1:0] staged;
  logic         armed;
  logic         waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged  <= W'(RST_VAL);
      act     <= W'(RST_VAL);
      armed   <= 1'b0;
      waiting <= 1'b0;
    end else begin
      if (!run) begin
        act     <= staged;
        armed   <= 1'b0;
        waiting <= 1'b0;
      end else begin
        if (boundary) begin
          if (armed) act <= staged;
          armed <= 1'b0;
        end
        if (grp_commit && waiting) begin
          armed   <= 1'b1;
          waiting <= 1'b0;
        end
      end
      if (we) begin
        staged <= din;
        if (run) begin
          armed   <= !sync;
          waiting <= sync;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int unsigned CNT_W = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(pwm_phase_pkg::MIN_PERIOD);
  logic [CNT_W-1:0] eff_per;

  always_comb begin
    eff_per = (period < MIN_P) ? MIN_P : period;
    wrap    = run && (cnt >= eff_per - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (wrap)    cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pwm_window_out.sv
module pwm_window_out #(
  parameter int unsigned CNT_W = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] shift,
  input  logic             pol,
  output logic             pwm_out,
  output logic             period_end
);
  logic in_window;
  assign in_window = (cnt >= shift) && (cnt < duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out    <= 1'b0;
      period_end <= 1'b0;
    end else if (!run) begin
      pwm_out    <= pol;
      period_end <= 1'b0;
    end else begin
      pwm_out    <= pol ^ in_window;
      period_end <= wrap;
    end
  end
endmodule

// File: rtl/pwm_phase_channel.sv
module pwm_phase_channel #(
  parameter int unsigned CNT_W = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic             cfg_sync,
  input  logic [CNT_W-1:0] cfg_data,
  input  logic             grp_commit,
  output logic             pwm_out,
  output logic             period_end
);
  import pwm_phase_pkg::*;

  logic [NUM_CNT_FIELDS-1:0][CNT_W-1:0] act_cnt;
  logic [CNT_W-1:0] act_period, act_duty, act_shift;
  logic             act_pol;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  for (genvar i = 0; i < NUM_CNT_FIELDS; i++) begin : g_fld
    pwm_stage_field #(
      .W      (CNT_W),
      .RST_VAL((i == int'(FLD_PERIOD)) ? MIN_PERIOD : 0)
    ) u_fld (
      .clk       (clk),
      .rst       (rst),
      .run       (enable),
      .boundary  (wrap),
      .grp_commit(grp_commit),
      .we        (cfg_we && (cfg_sel == 2'(i))),
      .sync      (cfg_sync),
      .din       (cfg_data),
      .act       (act_cnt[i])
    );
  end

  pwm_stage_field #(.W(1), .RST_VAL(0)) u_pol (
    .clk       (clk),
    .rst       (rst),
    .run       (enable),
    .boundary  (wrap),
    .grp_commit(grp_commit),
    .we        (cfg_we && (cfg_sel == FLD_POL)),
    .sync      (cfg_sync),
    .din       (cfg_data[0]),
    .act       (act_pol)
  );

  assign act_period = act_cnt[FLD_PERIOD];
  assign act_duty   = act_cnt[FLD_DUTY];
  assign act_shift  = act_cnt[FLD_SHIFT];

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (enable),
    .period(act_period),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  pwm_window_out #(.CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .run       (enable),
    .wrap      (wrap),
    .cnt       (cnt),
    .duty      (act_duty),
    .shift     (act_shift),
    .pol       (act_pol),
    .pwm_out   (pwm_out),
    .period_end(period_end)
  );
endmodule

// File: rtl/pwm_phase_channel_chk.sv
module pwm_phase_channel_chk #(
  parameter int unsigned CNT_W = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             pwm_out,
  input logic             period_end,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_duty,
  input logic [CNT_W-1:0] act_shift,
  input logic             act_pol
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    period_end |=> !period_end); // R1

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < ((act_period < CNT_W'(2)) ? CNT_W'(2) : act_period)); // R1

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (enable && (act_shift >= act_duty)) |=> (pwm_out == $past(act_pol))); // R3

  AST_NO_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
    (enable && !wrap) |=> ($stable(act_period) && $stable(act_duty)
                           && $stable(act_shift) && $stable(act_pol))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0 && !period_end)); // R7
endmodule

bind pwm_phase_channel pwm_phase_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .pwm_out   (pwm_out),
  .period_end(period_end),
  .cnt       (cnt),
  .wrap      (wrap),
  .act_period(act_period),
  .act_duty  (act_duty),
  .act_shift (act_shift),
  .act_pol   (act_pol)
);

// File: tb/tb_pwm_phase_channel.sv
`timescale 1ns/1ps
module tb_pwm_phase_channel;
  localparam int CW = 34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic          cfg_sync = 1'b0;
  logic [CW-1:0] cfg_data = '0;
  logic          grp_commit = 1'b0;
  logic          pwm_out, period_end;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  pwm_phase_channel #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_sync(cfg_sync), .cfg_data(cfg_data), .grp_commit(grp_commit),
    .pwm_out(pwm_out), .period_end(period_end)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: index 0 period, 1 duty, 2 shift, 3 polarity
  longint stg[4];
  longint cur[4];
  bit     arm[4];
  bit     wt[4];
  longint mcnt;
  bit     m_out, m_end;

  always @(posedge clk) begin
    if (rst) begin
      foreach (stg[k]) begin
        stg[k] = (k == 0) ? 2 : 0;
        cur[k] = stg[k];
        arm[k] = 0;
        wt[k]  = 0;
      end
      mcnt = 0; m_out = 0; m_end = 0;
    end else begin
      if (!enable) begin
        m_out = cur[3][0];
        m_end = 0;
        mcnt  = 0;
        foreach (cur[k]) begin cur[k] = stg[k]; arm[k] = 0; wt[k] = 0; end
      end else begin
        longint ep;
        bit w;
        ep = (cur[0] < 2) ? 2 : cur[0];
        w = (mcnt >= ep - 1);
        m_out = cur[3][0] ^ ((mcnt >= cur[2]) && (mcnt < cur[1]));
        m_end = w;
        if (w) begin
          mcnt = 0;
          foreach (cur[k]) begin
            if (arm[k]) cur[k] = stg[k];
            arm[k] = 0;
          end
        end else mcnt++;
        if (grp_commit)
          foreach (wt[k]) if (wt[k]) begin arm[k] = 1; wt[k] = 0; end
      end
      if (cfg_we) begin
        stg[cfg_sel] = (cfg_sel == 2'd3) ? longint'(cfg_data[0]) : longint'(cfg_data);
        if (enable) begin
          arm[cfg_sel] = !cfg_sync;
          wt[cfg_sel]  = cfg_sync;
        end
      end
    end
  end

  // every output cycle compared with the model (R2 window, R1 strobe, R5/R6 timing)
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(pwm_out == m_out, "R2 model out", pwm_out, m_out);
      chk(period_end == m_end, "R1 model strobe", period_end, m_end);
    end
  end

  task automatic wr(input int sel, input longint val, input bit sync);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_data = CW'(val); cfg_sync = sync;
    @(negedge clk);
    cfg_we = 0; cfg_sync = 0;
  endtask

  task automatic commit();
    @(negedge clk);
    grp_commit = 1;
    @(negedge clk);
    grp_commit = 0;
  endtask

  // waits for a strobe, then samples the next P output cycles (counts 0..P-1)
  task automatic measure(input int P, input int wr_at, input int sel, input longint val,
                         input bit sync, output int hi, output int first, output int end_at);
    hi = 0; first = -1; end_at = -1;
    do @(negedge clk); while (!period_end);
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (pwm_out) begin hi++; if (first < 0) first = k; end
      if (period_end && end_at < 0) end_at = k;
      if (k == wr_at) begin
        cfg_we = 1; cfg_sel = 2'(sel); cfg_data = CW'(val); cfg_sync = sync;
      end else begin
        cfg_we = 0; cfg_sync = 0;
      end
    end
    cfg_we = 0; cfg_sync = 0;
  endtask

  task automatic meas2(input int P, output int hi, output int first, output int end_at);
    measure(P, -1, 0, 0, 0, hi, first, end_at);
    measure(P, -1, 0, 0, 0, hi, first, end_at);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, first, ea, cyc;
    repeat (4) @(negedge clk);
    chk(pwm_out == 0, "R9 reset out", pwm_out, 0);
    chk(period_end == 0, "R9 reset strobe", period_end, 0);
    rst = 0;
    model_on = 1;

    // R7: writes while idle are taken at once; R2 basic window
    wr(0, 10, 1); wr(1, 7, 1); wr(2, 3, 0);
    @(negedge clk); enable = 1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!period_end && cyc < 100);
    chk(cyc == 10, "R7 first strobe after enable", cyc, 10);
    measure(10, -1, 0, 0, 0, hi, first, ea);
    chk(hi == 4, "R2 high time duty-shift", hi, 4);
    chk(first == 3, "R2 window start at shift", first, 3);
    chk(ea == 9, "R1 strobe spacing", ea, 9);

    // R5: mid-period write does not touch the current period
    measure(10, 2, 1, 9, 0, hi, first, ea);
    chk(hi == 4, "R5 period holding write", hi, 4);
    measure(10, -1, 0, 0, 0, hi, first, ea);
    chk(hi == 6, "R5 applied next period", hi, 6);

    // R11: other fields untouched
    chk(first == 3, "R11 shift unchanged by duty write", first, 3);

    // R6: sync write waits for commit
    wr(2, 1, 1);
    meas2(10, hi, first, ea);
    chk(hi == 6, "R6 held without commit", hi, 6);
    commit();
    meas2(10, hi, first, ea);
    chk(hi == 8, "R6 applied after commit", hi, 8);

    // R11: later write overrides the sync mode of an earlier one
    wr(2, 5, 1); wr(2, 3, 0);
    meas2(10, hi, first, ea);
    chk(hi == 6, "R11 later write decides", hi, 6);

    // R3: empty window
    wr(2, 9, 0);
    meas2(10, hi, first, ea);
    chk(hi == 0, "R3 shift equal duty", hi, 0);
    wr(2, 12, 0);
    meas2(10, hi, first, ea);
    chk(hi == 0, "R3 shift above duty", hi, 0);

    // R4: inverted polarity
    wr(2, 2, 0); wr(3, 1, 0);
    meas2(10, hi, first, ea);
    chk(hi == 3, "R4 inverted high count", hi, 3);
    chk(first == 0, "R4 inactive level high", first, 0);

    // R8: tiny periods
    wr(3, 0, 0); wr(2, 0, 0); wr(1, 1, 0); wr(0, 1, 0);
    meas2(2, hi, first, ea);
    chk(hi == 1, "R8 period 1 high", hi, 1);
    chk(ea == 1, "R8 period 1 spacing", ea, 1);
    wr(0, 0, 0);
    meas2(2, hi, first, ea);
    chk(ea == 1, "R8 period 0 spacing", ea, 1);

    // R10: half-period offset
    wr(0, 16, 1); wr(1, 4, 1); wr(2, 0, 1); commit();
    meas2(16, hi, first, ea);
    chk(first == 0 && hi == 4, "R10 reference phase", first, 0);
    wr(1, 12, 1); wr(2, 8, 1); commit();
    meas2(16, hi, first, ea);
    chk(first == 8, "R10 half-period start", first, 8);
    chk(hi == 4, "R10 half-period width", hi, 4);

    // R7: idle behaviour
    @(negedge clk); enable = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk(pwm_out == 0, "R7 idle out", pwm_out, 0);
        chk(period_end == 0, "R7 idle strobe", period_end, 0);
      end
    end
    wr(1, 5, 1); wr(2, 0, 1);
    @(negedge clk); enable = 1;
    hi = 0; cyc = 0;
    do begin @(negedge clk); cyc++; if (pwm_out) hi++; end while (!period_end && cyc < 100);
    chk(cyc == 16, "R7 restart from zero", cyc, 16);
    chk(hi == 5, "R7 idle writes applied", hi, 5);

    // random stress against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      cfg_we = ($urandom_range(0, 5) == 0);
      cfg_sel = 2'($urandom_range(0, 3));
      cfg_sync = $urandom_range(0, 1);
      cfg_data = (cfg_sel == 2'd0) ? CW'($urandom_range(0, 20)) : CW'($urandom_range(0, 22));
      grp_commit = ($urandom_range(0, 9) == 0);
      enable = ($urandom_range(0, 199) != 0);
    end
    @(negedge clk);
    cfg_we = 0; grp_commit = 0; enable = 1;
    repeat (40) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule